// File: doc/BRIEF.md
# Zero-Bypassing Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands one multiplier bit per clock, in the manner of a classic shift-and-add unit, but arranged to keep switching activity low. The multiplier operand is held still in a register for the whole operation. A one-hot ring of flip-flops steers a multiplexer to pick which multiplier bit is examined, so no binary counter and no shifting of the operand is needed.

The running upper partial product is held in one of two registers. The feed register sits in front of the adder and is written only when the next examined bit is one. The bypass register is written only when the next examined bit is zero, so the adder inputs stay quiet across runs of zero bits. The least significant bit produced by each step is written in place into a low-product bit array at the position the ring points to, instead of being shifted down a register.

A one-cycle start pulse captures both operands. After N steps the full 2N-bit product appears on a registered output together with a ready flag, and both hold until the next accepted start.

Top module: `zbm_mult`

## Requirements
- R1: A start pulse seen while idle captures a_in and b_in; changes on a_in and b_in after that clock edge do not alter the result of the operation in progress.
- R2: On an accepted start the one-hot ring is set to position 0 and then advances by one position per clock while busy; the captured multiplier operand does not change during an operation.
- R3: A zero multiplier bit adds nothing to the product, and the feed register in front of the adder keeps its value on a step whose following bit is zero.
- R4: A one multiplier bit at position k adds the multiplicand weighted by 2^k, carries included, and the bypass register keeps its value on a step whose following bit is one.
- R5: If start is sampled high while idle at clock edge E0, ready is low after edges E0..E(N-1) and high after edge EN; ready and busy are never high together.
- R6: While ready is high, product equals a*b as an unsigned 2N-bit value, for every operand pair including zero and all-ones operands.
- R7: Product and ready hold their values until the next accepted start; ready is low after the edge that accepts a start.
- R8: A start pulse while an operation is running is ignored: the running result and its timing are unchanged.
- R9: After reset, ready is 0 and product is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| a_in | input | N | Multiplicand, captured on an accepted start |
| b_in | input | N | Multiplier, captured on an accepted start |
| product | output | 2N | Registered unsigned product, valid while ready is high |
| ready | output | 1 | High once all N multiplier bits have been processed |

## Verification
The bench targets multiplier patterns that stress the feed/bypass handover: B zero (a design that never loads the bypass register at start would return stale data), B all ones (a carry dropped between steps shows up in the top bits), and A zero with B nonzero. It changes the operand inputs mid-run and fires start while busy, which catches a design that reads live inputs or restarts the ring. The ready edge is checked one cycle on either side, so an off-by-one ring or a product composed before the last low bit is written is reported, and held results after completion catch outputs that drift.

// File: rtl/zbm_pkg.sv
package zbm_pkg;
  // Which register holds the current upper partial product
  typedef enum logic {
    SRC_BYPASS = 1'b0,
    SRC_FEED   = 1'b1
  } pp_src_e;
endpackage

// File: rtl/zbm_ring.sv
module zbm_ring #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  output logic [N-1:0] ring_o,
  output logic [N-1:0] ring_nxt_o
);
  logic [N-1:0] ring_q;

  assign ring_nxt_o = {ring_q[N-2:0], ring_q[N-1]};
  assign ring_o     = ring_q;

  always_ff @(posedge clk) begin
    if (rst)       ring_q <= '0;
    else if (load) ring_q <= N'(1);
    else if (adv)  ring_q <= ring_nxt_o;
  end

  // R2: position is always exactly one while stepping
  p_ring_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    adv |-> $onehot(ring_q));
  // R2: an accepted start homes the ring
  p_ring_home_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> ring_q == N'(1));
  // R2: stepping moves one place
  p_ring_step_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> ring_q == {$past(ring_q[N-2:0]), $past(ring_q[N-1])});
endmodule

// File: rtl/zbm_bitsel.sv
module zbm_bitsel #(
  parameter int N = 8
) (
  input  logic [N-1:0] bits_i,
  input  logic [N-1:0] sel_i,
  output logic         bit_o
);
  assign bit_o = |(bits_i & sel_i);
endmodule

// File: rtl/zbm_step.sv
module zbm_step
  import zbm_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         init_bit,
  input  logic         step,
  input  logic         next_bit,
  input  logic [N-1:0] a_i,
  output logic [N-1:0] pp_o,
  output logic         lsb_o
);
  logic [N-1:0] fa_q;
  logic [N-1:0] bp_q;
  pp_src_e      src_q;
  logic [N:0]   add_w;
  logic [N:0]   sum_w;

  // adder sees only the feed register and the multiplicand
  assign add_w = {1'b0, fa_q} + {1'b0, a_i};
  assign sum_w = (src_q == SRC_FEED) ? add_w : {1'b0, bp_q};
  assign pp_o  = sum_w[N:1];
  assign lsb_o = sum_w[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q  <= '0;
      bp_q  <= '0;
      src_q <= SRC_BYPASS;
    end else if (init) begin
      src_q <= init_bit ? SRC_FEED : SRC_BYPASS;
      if (init_bit) fa_q <= '0;
      else          bp_q <= '0;
    end else if (step) begin
      src_q <= next_bit ? SRC_FEED : SRC_BYPASS;
      if (next_bit) fa_q <= pp_o;
      else          bp_q <= pp_o;
    end
  end

  // R3: adder operand stays quiet when the next bit is zero
  p_feed_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !init && !next_bit) |=> $stable(fa_q));
  // R4: bypass register untouched when the next bit is one
  p_bypass_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !init && next_bit) |=> $stable(bp_q));
endmodule

// File: rtl/zbm_mult.sv
module zbm_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic [2*N-1:0] product,
  output logic           ready
);
  localparam int PW = 2 * N;

  logic [N-1:0]  a_q;
  logic [N-1:0]  b_q;
  logic          busy_q;
  logic          ready_q;
  logic [PW-1:0] prod_q;
  logic [N-1:0]  lo_q;
  logic [N-1:0]  lo_w;
  logic [N-1:0]  ring_w;
  logic [N-1:0]  ring_nxt_w;
  logic          next_bit_w;
  logic [N-1:0]  pp_w;
  logic          lsb_w;
  logic          accept_w;
  logic          last_w;

  assign accept_w = start && !busy_q;
  assign last_w   = busy_q && ring_w[N-1];

  zbm_ring #(.N(N)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .load      (accept_w),
    .adv       (busy_q),
    .ring_o    (ring_w),
    .ring_nxt_o(ring_nxt_w)
  );

  zbm_bitsel #(.N(N)) u_bitsel (
    .bits_i(b_q),
    .sel_i (ring_nxt_w),
    .bit_o (next_bit_w)
  );

  zbm_step #(.N(N)) u_step (
    .clk     (clk),
    .rst     (rst),
    .init    (accept_w),
    .init_bit(b_in[0]),
    .step    (busy_q),
    .next_bit(next_bit_w),
    .a_i     (a_q),
    .pp_o    (pp_w),
    .lsb_o   (lsb_w)
  );

  // low product bits written in place at the ring position
  for (genvar i = 0; i < N; i++) begin : g_lo
    assign lo_w[i] = ring_w[i] ? lsb_w : lo_q[i];
    always_ff @(posedge clk) begin
      if (rst)                      lo_q[i] <= 1'b0;
      else if (busy_q && ring_w[i]) lo_q[i] <= lsb_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      prod_q  <= '0;
    end else if (accept_w) begin
      a_q     <= a_in;
      b_q     <= b_in;
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
    end else if (last_w) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
      prod_q  <= {pp_w, lo_w};
    end
  end

  assign product = prod_q;
  assign ready   = ready_q;

  // R1, R2: operands frozen for the whole run
  p_ops_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(b_q) && $stable(a_q));
  // R5: ready only rises at the end of a run
  p_ready_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(busy_q));
  // R5: never ready and busy together
  p_ready_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(ready_q && busy_q));
  // R7: result held until a new start
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !start) |=> ready_q && $stable(prod_q));
  // R8: start during a run leaves it running
  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !last_w) |=> busy_q);
endmodule

// File: tb/test_zbm_mult.sv
module test_zbm_mult;
  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [N-1:0]  a_in;
  logic [N-1:0]  b_in;
  logic [PW-1:0] product;
  logic          ready;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  zbm_mult #(.N(N)) i_zbm_mult (
    .clk(clk), .rst(rst), .start(start),
    .a_in(a_in), .b_in(b_in), .product(product), .ready(ready)
  );

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full operation; mid-run inputs are scrambled (R1)
  task automatic t_run(input string req, input logic [N-1:0] a, input logic [N-1:0] b);
    logic [PW-1:0] exp;
    exp = PW'(a) * PW'(b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_in = ~a; b_in = b ^ 8'h5a;
    repeat (N - 1) @(negedge clk);
    chk({req, " R5 ready early"}, PW'(ready), PW'(0));
    @(negedge clk);
    chk({req, " R5 ready"}, PW'(ready), PW'(1));
    chk({req, " R6 R1 product"}, product, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 ready", PW'(ready), PW'(0));
    chk("R9 product", product, '0);
  endtask

  task automatic t_corners;
    t_run("R3 B=0", 8'hb7, 8'h00);
    t_run("R4 B=ones", 8'hff, 8'hff);
    t_run("R4 A=ones B=ones-1", 8'hff, 8'hfe);
    t_run("R6 A=0", 8'h00, 8'hd3);
    t_run("R3 sparse B", 8'h9c, 8'h81);
    t_run("R4 B=1", 8'h6e, 8'h01);
    t_run("R4 B=msb", 8'h6e, 8'h80);
    t_run("R3 alt B", 8'hc5, 8'haa);
  endtask

  task automatic t_random;
    for (int i = 0; i < 40; i++) begin
      t_run("R6 random", N'($urandom), N'($urandom));
    end
  endtask

  task automatic t_hold;
    t_run("R7 setup", 8'h37, 8'h29);
    repeat (6) @(negedge clk);
    chk("R7 ready held", PW'(ready), PW'(1));
    chk("R7 product held", product, PW'(16'h37 * 16'h29));
    a_in = 8'h11; b_in = 8'h22; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 ready drops on start", PW'(ready), PW'(0));
    repeat (N) @(negedge clk);
    chk("R7 next result", product, PW'(16'h11 * 16'h22));
  endtask

  task automatic t_busy_start;
    @(negedge clk);
    a_in = 8'hd9; b_in = 8'h7b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    a_in = 8'h03; b_in = 8'h04; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N - 5) @(negedge clk);
    chk("R8 ready early", PW'(ready), PW'(0));
    @(negedge clk);
    chk("R8 ready", PW'(ready), PW'(1));
    chk("R8 product", product, PW'(16'hd9 * 16'h7b));
  endtask

  initial begin
    t_reset;
    t_corners;
    t_random;
    t_hold;
    t_busy_start;
    t_run("R2 back-to-back", 8'h80, 8'hff);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule